// File: doc/BRIEF.md
# SAR Conversion Timing Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. Once it sees a start pulse, it steps through an initial sampling phase, then one trial comparison per result bit, then an end-processing phase. It drives the trial code to an external DAC and reads back a one-bit comparator decision for each trial. The analog comparator, the DAC and the hold capacitor live outside the block.

The sequencer runs on a clock at twice the rate of the converter clock. One tick of `clk` is therefore half a converter cycle, and fractional phase lengths such as 2.5 cycles become whole tick counts. There are two settings, a sample-and-hold option and a resolution select. Both are captured when the conversion starts. With sample-and-hold off, every bit after the first is re-sampled before it is compared. With it on, the input is sampled once and the bits are compared back to back.

Start and done are plain control pins with no handshake. `result` holds its value from one done pulse to the next, so a consumer may read it at any time between conversions.

Top module: `sar_conv_sequencer`

## Requirements
- R1: Every conversion starts with a sampling phase of 8 ticks (4 converter cycles), during which `sample_strobe` is high.
- R2: With sample-and-hold off, the first comparison lasts 4 ticks. Each later bit has 5 ticks of sampling followed by 5 ticks of comparison, so `sample_strobe` is high for 8+5·(N−1) ticks and `compare_strobe` for 4+5·(N−1) ticks, where N is the bit count.
- R3: With sample-and-hold on, the only sampling is the initial one. The first comparison and each later comparison last 5 ticks, so `compare_strobe` is high for 5·N ticks.
- R4: End processing lasts 16 ticks with sample-and-hold off and 8 ticks with it on. `busy` is high for 98 ticks (8-bit) or 118 ticks (10-bit) with the option off, and 56 or 66 ticks with it on.
- R5: Bits are decided MSB first. The bit under trial is set in `dac_code` and kept only if `cmp_above` is 1 (input at or above the DAC level) on the last tick of its comparison. With an ideal comparator the result equals the input value, saturated to the code range.
- R6: When `wide_res` is 0 the conversion is 8 bits. The result is right-aligned in `result[7:0]`, and `result[9:8]` and `dac_code[9:8]` stay 0.
- R7: `sh_en` and `wide_res` are captured on the accepted start. Changes to them while `busy` is high have no effect on the timing or the width of that conversion.
- R8: A `start` pulse while `busy` is high is ignored. The running conversion keeps its length and gives exactly one done pulse.
- R9: `done` is high for exactly one tick, on the tick that follows the final end-processing tick. `busy` is low on that tick and `result` takes the new value on that same tick.
- R10: Synchronous reset `rst` returns the block to idle, with `busy` low. It clears `result` and produces no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the converter clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-tick request to begin a conversion |
| sh_en | input | 1 | Sample-and-hold option, captured at start |
| wide_res | input | 1 | 1 selects 10-bit, 0 selects 8-bit, captured at start |
| cmp_above | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dac_code | output | 10 | Trial code for the external DAC |
| sample_strobe | output | 1 | High while the input is being sampled |
| compare_strobe | output | 1 | High while a bit comparison is running |
| busy | output | 1 | High from the tick after the start until the conversion ends |
| done | output | 1 | One-tick pulse marking a new result |
| result | output | 10 | Last converted value |

## Verification
The conversion is run in all four combinations of resolution and sample-and-hold, with inputs of zero, full scale, alternating bit patterns and a value above the 8-bit range in 8-bit mode. Zero and full scale catch a keep/clear decision that is stuck one way. The alternating patterns catch a bit order or bit index that is off by one. The over-range 8-bit case shows the saturation and the zero upper bits. Tick counts of busy, the sampling strobe and the compare strobe separate the per-bit timing of the two options, including the 4-tick versus 5-tick first comparison. Further runs toggle the settings and pulse start in the middle of a conversion, and assert reset partway through a conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SAMPLE  = 2'd1,
    PH_COMPARE = 2'd2,
    PH_FINISH  = 2'd3
  } phase_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sar_phase_timer.sv
module sar_phase_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sar_bit_register.sv
module sar_bit_register #(
  parameter int NB = 10,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          decide,
  input  logic          keep,
  input  logic [IW-1:0] dec_idx,
  input  logic          set_trial,
  input  logic [IW-1:0] set_idx,
  output logic [NB-1:0] code
);
  logic [NB-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst || clear) code_q <= '0;
    else begin
      for (int i = 0; i < NB; i++) begin
        if (decide && !keep && dec_idx == i[IW-1:0]) code_q[i] <= 1'b0;
        if (set_trial && set_idx == i[IW-1:0])       code_q[i] <= 1'b1;
      end
    end
  end

  assign code = code_q;

  // R5
  bit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (decide && !keep && !clear && !(set_trial && set_idx == dec_idx))
      |=> !code_q[$past(dec_idx)]);
endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer
  import sar_seq_pkg::*;
#(
  parameter int NB_WIDE         = 10,
  parameter int NB_NARROW       = 8,
  parameter int T_SAMPLE0       = 8,
  parameter int T_CMP0_PLAIN    = 4,
  parameter int T_CMP0_HOLD     = 5,
  parameter int T_RESAMPLE      = 5,
  parameter int T_CMP           = 5,
  parameter int T_END_PLAIN     = 16,
  parameter int T_END_HOLD      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               sh_en,
  input  logic               wide_res,
  input  logic               cmp_above,
  output logic [NB_WIDE-1:0] dac_code,
  output logic               sample_strobe,
  output logic               compare_strobe,
  output logic               busy,
  output logic               done,
  output logic [NB_WIDE-1:0] result
);
  localparam int IW   = $clog2(NB_WIDE);
  localparam int MAXT = imax(imax(imax(T_SAMPLE0, T_CMP0_PLAIN), imax(T_CMP0_HOLD, T_RESAMPLE)),
                             imax(T_CMP, imax(T_END_PLAIN, T_END_HOLD)));
  localparam int CW   = $clog2(MAXT + 1);

  phase_t              phase_q, phase_n;
  logic                hold_q, wide_q, first_q, first_n;
  logic [IW-1:0]       idx_q, idx_n;
  logic                done_q;
  logic [NB_WIDE-1:0]  result_q, code;

  logic                t_load, t_expired;
  logic [CW-1:0]       t_val;
  logic                r_clear, r_decide, r_set;
  logic [IW-1:0]       r_set_idx;

  function automatic logic [CW-1:0] ticks(input int n);
    return CW'(n - 1);
  endfunction

  sar_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_expired)
  );

  sar_bit_register #(.NB(NB_WIDE)) u_bits (
    .clk(clk), .rst(rst), .clear(r_clear), .decide(r_decide), .keep(cmp_above),
    .dec_idx(idx_q), .set_trial(r_set), .set_idx(r_set_idx), .code(code)
  );

  always_comb begin
    phase_n   = phase_q;
    idx_n     = idx_q;
    first_n   = first_q;
    t_load    = 1'b0;
    t_val     = '0;
    r_clear   = 1'b0;
    r_decide  = 1'b0;
    r_set     = 1'b0;
    r_set_idx = idx_q;
    unique case (phase_q)
      PH_IDLE: if (start) begin
        phase_n = PH_SAMPLE;
        t_load  = 1'b1;
        t_val   = ticks(T_SAMPLE0);
        r_clear = 1'b1;
        idx_n   = wide_res ? IW'(NB_WIDE - 1) : IW'(NB_NARROW - 1);
        first_n = 1'b1;
      end
      PH_SAMPLE: if (t_expired) begin
        phase_n = PH_COMPARE;
        t_load  = 1'b1;
        t_val   = !first_q ? ticks(T_CMP) :
                  (hold_q ? ticks(T_CMP0_HOLD) : ticks(T_CMP0_PLAIN));
        r_set   = 1'b1;
      end
      PH_COMPARE: if (t_expired) begin
        r_decide = 1'b1;
        t_load   = 1'b1;
        if (idx_q == '0) begin
          phase_n = PH_FINISH;
          t_val   = hold_q ? ticks(T_END_HOLD) : ticks(T_END_PLAIN);
        end else begin
          idx_n   = idx_q - 1'b1;
          first_n = 1'b0;
          if (hold_q) begin
            t_val     = ticks(T_CMP);
            r_set     = 1'b1;
            r_set_idx = idx_q - 1'b1;
          end else begin
            phase_n = PH_SAMPLE;
            t_val   = ticks(T_RESAMPLE);
          end
        end
      end
      PH_FINISH: if (t_expired) phase_n = PH_IDLE;
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      idx_q    <= '0;
      first_q  <= 1'b0;
      hold_q   <= 1'b0;
      wide_q   <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      phase_q <= phase_n;
      idx_q   <= idx_n;
      first_q <= first_n;
      done_q  <= 1'b0;
      if (phase_q == PH_IDLE && start) begin
        hold_q <= sh_en;
        wide_q <= wide_res;
      end
      if (phase_q == PH_FINISH && t_expired) begin
        done_q   <= 1'b1;
        result_q <= code;
      end
    end
  end

  assign dac_code       = code;
  assign sample_strobe  = (phase_q == PH_SAMPLE);
  assign compare_strobe = (phase_q == PH_COMPARE);
  assign busy           = (phase_q != PH_IDLE);
  assign done           = done_q;
  assign result         = result_q;

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  hold_no_resample_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && hold_q && sample_strobe) |-> first_q);

  // R6
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !wide_q) |-> (code[NB_WIDE-1:NB_NARROW] == '0));
endmodule

// File: tb/sar_conv_sequencer_bench.sv
module sar_conv_sequencer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0, sh_en = 1'b0, wide_res = 1'b0;
  logic [9:0] vin = '0;
  logic [9:0] dac_code, result;
  logic       sample_strobe, compare_strobe, busy, done, cmp_above;
  int         n_checks = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp_above = (vin >= dac_code);

  sar_conv_sequencer u_sar_conv_sequencer (
    .clk(clk), .rst(rst), .start(start), .sh_en(sh_en), .wide_res(wide_res),
    .cmp_above(cmp_above), .dac_code(dac_code), .sample_strobe(sample_strobe),
    .compare_strobe(compare_strobe), .busy(busy), .done(done), .result(result)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_conv(input bit hold, input bit wide, input logic [9:0] v,
                          input bit flip_mid, input bit restart_mid);
    int nb, busy_n, smp_n, cmp_n, first_smp, done_in, ticks;
    int exp_val, smp_exp, cmp_exp, busy_exp;
    bit upper_bad, in_first;
    nb = wide ? 10 : 8;
    @(negedge clk);
    vin = v; sh_en = hold; wide_res = wide; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_n = 0; smp_n = 0; cmp_n = 0; first_smp = 0; done_in = 0;
    upper_bad = 1'b0; in_first = 1'b1;
    while (busy && busy_n < 1000) begin
      busy_n++;
      if (sample_strobe) smp_n++;
      if (compare_strobe) cmp_n++;
      if (in_first && sample_strobe) first_smp++; else in_first = 1'b0;
      if (done) done_in++;
      if (!wide && dac_code[9:8] != 2'b00) upper_bad = 1'b1;
      if (flip_mid && busy_n == 20) begin sh_en = !hold; wide_res = !wide; end
      if (restart_mid && busy_n == 30) start = 1'b1;
      if (restart_mid && busy_n == 31) start = 1'b0;
      @(negedge clk);
    end
    exp_val  = wide ? int'(v) : ((v > 10'd255) ? 255 : int'(v));
    smp_exp  = hold ? 8 : 8 + 5*(nb-1);
    cmp_exp  = hold ? 5*nb : 4 + 5*(nb-1);
    busy_exp = hold ? (wide ? 66 : 56) : (wide ? 118 : 98);
    ticks    = busy_exp;
    check("R1", "initial sampling ticks", first_smp, 8);
    check(hold ? "R3" : "R2", "sample strobe ticks", smp_n, smp_exp);
    check(hold ? "R3" : "R2", "compare strobe ticks", cmp_n, cmp_exp);
    check(flip_mid ? "R7" : (restart_mid ? "R8" : "R4"), "busy ticks", busy_n, ticks);
    check("R9", "done pulses while busy", done_in, 0);
    check("R9", "done on busy fall", int'(done), 1);
    check(wide ? "R5" : "R6", "result", int'(result), exp_val);
    if (!wide) check("R6", "dac upper bits stayed zero", int'(upper_bad), 0);
    @(negedge clk);
    check("R9", "done one tick only", int'(done), 0);
    check("R8", "no restart after done", int'(busy), 0);
  endtask

  task automatic t_reset_state();
    check("R10", "busy after reset", int'(busy), 0);
    check("R10", "result after reset", int'(result), 0);
    check("R10", "done after reset", int'(done), 0);
  endtask

  task automatic t_modes();
    run_conv(1'b0, 1'b1, 10'd0,    1'b0, 1'b0);
    run_conv(1'b0, 1'b1, 10'd1023, 1'b0, 1'b0);
    run_conv(1'b0, 1'b1, 10'h2AA,  1'b0, 1'b0);
    run_conv(1'b1, 1'b1, 10'h155,  1'b0, 1'b0);
    run_conv(1'b1, 1'b1, 10'd512,  1'b0, 1'b0);
    run_conv(1'b0, 1'b0, 10'd165,  1'b0, 1'b0);
    run_conv(1'b1, 1'b0, 10'd90,   1'b0, 1'b0);
    run_conv(1'b1, 1'b0, 10'd900,  1'b0, 1'b0);
  endtask

  task automatic t_settings_latched();
    run_conv(1'b0, 1'b1, 10'h2D3, 1'b1, 1'b0);
    run_conv(1'b1, 1'b0, 10'd77,  1'b1, 1'b0);
  endtask

  task automatic t_start_while_busy();
    run_conv(1'b1, 1'b1, 10'h1E7, 1'b0, 1'b1);
    run_conv(1'b0, 1'b0, 10'd200, 1'b0, 1'b1);
  endtask

  task automatic t_reset_mid();
    int dn;
    dn = 0;
    @(negedge clk);
    vin = 10'd300; sh_en = 1'b0; wide_res = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10", "busy after mid reset", int'(busy), 0);
    check("R10", "result cleared by reset", int'(result), 0);
    repeat (130) begin
      if (done) dn++;
      @(negedge clk);
    end
    check("R10", "no done after reset", dn, 0);
    check("R10", "still idle", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_modes();
    t_settings_latched();
    t_start_while_busy();
    t_reset_mid();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule